// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

This block is the receive half of a CPU-programmed serial port. Bits arrive on a serial line and are timed by an external receive clock, which runs at one, sixteen or sixty-four times the bit rate. A processor sets the port up over a small 8-bit parallel bus, then collects each finished character together with a status byte. A ready output and three sticky error outputs let the processor poll the port or take an interrupt from it.

Setup follows a fixed order. After reset, the first write to the control address is taken as the mode word. The mode word picks the clock factor, the character length and the parity. Every later control write is a command word. A command word can enable reception, clear the error flags, or send the port back to waiting for a new mode word. The receiver stays idle until a mode word and then a command word have both been written.

The receive clock is sampled in the system clock domain through a synchronizer, and the block reacts to each rising edge of that clock. In the 16x and 64x modes, a start bit is checked again halfway through the bit period, and every later bit is sampled at its middle.

Top module: `async_rx_port`

## Requirements
- R1: Character length is set by mode bits [3:2] (00=5, 01=6, 10=7, 11=8 data bits). Data is received LSB first and is right-justified in the data register, with the unused upper bits read as zero.
- R2: Mode bits [1:0] select the receive-clock factor: 01=1x, 10=16x, 11=64x (00 behaves as 1x). The line is sampled on rising edges of `rxc`.
- R3: After reset, the first write to address 1 loads the mode word and every later write there is a command word. No character is received until both have been written.
- R4: Command bit 2 enables reception. While it is 0, characters on the line do not raise `rx_ready`.
- R5: Mode bit 4 enables a parity bit after the data bits, and mode bit 5 selects even (1) or odd (0) parity. A mismatch sets the parity error flag.
- R6: A stop bit sampled low sets the framing error flag. The character is still delivered.
- R7: If a new character completes while `rx_ready` is still set, the overrun flag is set and the new character replaces the old one.
- R8: `rx_ready` rises when a character completes and clears when the CPU reads the data register (address 0).
- R9: The error flags stay set until a command word with bit 4 set is written. A command word without bit 4 leaves them unchanged.
- R10: In 16x and 64x modes, a low level on the line that is gone by the middle of the start bit does not start a character.
- R11: A command word with bit 6 set stops reception, clears `rx_ready` and the error flags, and makes the next control write a mode word again.
- R12: Reading address 1 returns the status byte: bit 1 ready, bit 3 parity error, bit 4 overrun, bit 5 framing error, all other bits zero. `rdata` is zero when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for bus accesses |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| addr | input | 1 | 0 = data register, 1 = control/status |
| wdata | input | 8 | Write data (mode or command word) |
| rdata | output | 8 | Read data (character or status) |
| rxc | input | 1 | External receive clock |
| rxd | input | 1 | Serial data line, idle high |
| rx_ready | output | 1 | A character is waiting |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun |
| err_frame | output | 1 | Sticky framing error |

## Verification
The bench uses the default parameters: a two-stage synchronizer, a maximum clock factor of 64 and 8-bit characters. With these values all three clock factors and all four character lengths can be chosen, so random mode words cover every combination of length, parity and factor. Directed cases use the 16x factor for the start-glitch test and the bad-stop-bit test. In that mode a short low pulse can be rejected at mid-bit, and the low level left over from a missing stop bit is not taken as a new start.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    PH_MODE, PH_CMD, PH_RUN
  } phase_e;

  // mode word layout, low six bits of the control write
  typedef struct packed {
    logic       par_even;
    logic       par_en;
    logic [1:0] len_code;
    logic [1:0] fac_code;
  } mode_t;

  localparam int CMD_RX_EN   = 2;
  localparam int CMD_ERR_CLR = 4;
  localparam int CMD_REMODE  = 6;

endpackage

// File: rtl/rxp_sync.sv
module rxp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxc_i,
  input  logic rxd_i,
  output logic tick_o,
  output logic rxd_o
);

  logic [STAGES-1:0] c_q, d_q;
  logic              c_prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          c_q <= '0;
          d_q <= '1;
        end else begin
          c_q <= rxc_i;
          d_q <= rxd_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          c_q <= '0;
          d_q <= '1;
        end else begin
          c_q <= {c_q[STAGES-2:0], rxc_i};
          d_q <= {d_q[STAGES-2:0], rxd_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_prev_q <= 1'b0;
    else        c_prev_q <= c_q[STAGES-1];
  end

  assign tick_o = c_q[STAGES-1] & ~c_prev_q;
  assign rxd_o  = d_q[STAGES-1];

endmodule

// File: rtl/rxp_frame.sv
module rxp_frame
  import rxp_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int FAC_MAX  = 64,
  localparam int CNT_W   = $clog2(FAC_MAX),
  localparam int IDX_W   = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                tick,
  input  logic                rxd,
  input  mode_t               mode,
  output logic                done_o,
  output logic [MAX_BITS-1:0] char_o,
  output logic                perr_o,
  output logic                ferr_o
);

  rx_state_e           st_q, st_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d, fac_m1, half_m1;
  logic [IDX_W-1:0]    idx_q, idx_d, nbits_m1;
  logic [MAX_BITS-1:0] sh_q, sh_d;
  logic                par_q, par_d, perr_q, perr_d, ferr_q, ferr_d, done_q, done_d;
  logic                one_x;

  always_comb begin
    one_x    = 1'b0;
    fac_m1   = '0;
    half_m1  = '0;
    case (mode.fac_code)
      2'b10:   begin fac_m1 = CNT_W'(15); half_m1 = CNT_W'(7);  end
      2'b11:   begin fac_m1 = CNT_W'(63); half_m1 = CNT_W'(31); end
      default: one_x = 1'b1;
    endcase
    nbits_m1 = IDX_W'(4) + IDX_W'(mode.len_code);
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    par_d  = par_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    done_d = 1'b0;
    if (!run) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: if (!rxd) begin
          cnt_d  = '0;
          idx_d  = '0;
          sh_d   = '0;
          par_d  = 1'b0;
          perr_d = 1'b0;
          st_d   = one_x ? RX_DATA : RX_START;
        end
        RX_START: begin
          if (cnt_q == half_m1) begin
            cnt_d = '0;
            st_d  = rxd ? RX_IDLE : RX_DATA;
          end else cnt_d = cnt_q + 1'b1;
        end
        RX_DATA: begin
          if (cnt_q == fac_m1) begin
            cnt_d        = '0;
            sh_d[idx_q]  = rxd;
            par_d        = par_q ^ rxd;
            if (idx_q == nbits_m1) st_d = mode.par_en ? RX_PAR : RX_STOP;
            else                   idx_d = idx_q + 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        RX_PAR: begin
          if (cnt_q == fac_m1) begin
            cnt_d  = '0;
            perr_d = par_q ^ rxd ^ ~mode.par_even;
            st_d   = RX_STOP;
          end else cnt_d = cnt_q + 1'b1;
        end
        RX_STOP: begin
          if (cnt_q == fac_m1) begin
            cnt_d  = '0;
            ferr_d = ~rxd;
            done_d = 1'b1;
            st_d   = RX_IDLE;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign char_o = sh_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;

  // R1: bits above the programmed length are never set in a delivered character
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((32'(sh_q) >> (int'(nbits_m1) + 1)) == 0));

  // R10: a character never completes without the engine having been busy
  a_r10_no_instant_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_IDLE && !done_q) |=> !done_q);

endmodule

// File: rtl/rxp_host.sv
module rxp_host
  import rxp_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic                rd,
  input  logic                wr,
  input  logic                addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  input  logic                done,
  input  logic [MAX_BITS-1:0] char_in,
  input  logic                perr_in,
  input  logic                ferr_in,
  output mode_t               mode,
  output logic                run,
  output logic                rdy,
  output logic                pe,
  output logic                oe,
  output logic                fe
);

  phase_e              ph_q, ph_d;
  mode_t               mode_q, mode_d;
  logic                en_q, en_d, rdy_q, rdy_d;
  logic                pe_q, pe_d, oe_q, oe_d, fe_q, fe_d;
  logic [MAX_BITS-1:0] dat_q, dat_d;
  logic                wr_ctl, rd_dat, rd_any;
  logic [1:0]          unused_wbits;

  assign wr_ctl       = cs & wr & addr;
  assign rd_dat       = cs & rd & ~addr;
  assign rd_any       = cs & rd;
  assign unused_wbits = wdata[7:6] & {1'b1, ~wdata[CMD_REMODE]};

  always_comb begin
    ph_d   = ph_q;
    mode_d = mode_q;
    en_d   = en_q;
    rdy_d  = rdy_q;
    pe_d   = pe_q;
    oe_d   = oe_q;
    fe_d   = fe_q;
    dat_d  = dat_q;
    if (wr_ctl) begin
      if (ph_q == PH_MODE) begin
        mode_d = mode_t'(wdata[5:0]);
        ph_d   = PH_CMD;
      end else if (wdata[CMD_REMODE]) begin
        ph_d  = PH_MODE;
        en_d  = 1'b0;
        rdy_d = 1'b0;
        pe_d  = 1'b0;
        oe_d  = 1'b0;
        fe_d  = 1'b0;
      end else begin
        ph_d = PH_RUN;
        en_d = wdata[CMD_RX_EN];
        if (wdata[CMD_ERR_CLR]) begin
          pe_d = 1'b0;
          oe_d = 1'b0;
          fe_d = 1'b0;
        end
      end
    end
    if (rd_dat) rdy_d = 1'b0;
    if (done) begin
      dat_d = char_in;
      rdy_d = 1'b1;
      if (rdy_q && !rd_dat) oe_d = 1'b1;
      if (perr_in) pe_d = 1'b1;
      if (ferr_in) fe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_MODE;
      mode_q <= '0;
      en_q   <= 1'b0;
      rdy_q  <= 1'b0;
      pe_q   <= 1'b0;
      oe_q   <= 1'b0;
      fe_q   <= 1'b0;
      dat_q  <= '0;
    end else begin
      ph_q   <= ph_d;
      mode_q <= mode_d;
      en_q   <= en_d;
      rdy_q  <= rdy_d;
      pe_q   <= pe_d;
      oe_q   <= oe_d;
      fe_q   <= fe_d;
      dat_q  <= dat_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_any) begin
      if (addr) rdata = {2'b00, fe_q, oe_q, pe_q, 1'b0, rdy_q, 1'b0};
      else      rdata = 8'(dat_q);
    end
  end

  assign mode = mode_q;
  assign run  = (ph_q == PH_RUN) & en_q;
  assign rdy  = rdy_q;
  assign pe   = pe_q;
  assign oe   = oe_q;
  assign fe   = fe_q;

  // R8: a completed character always leaves the ready flag set
  a_r8_ready_after_char: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rdy_q);

  // R7: a character landing on an unread one flags overrun
  a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rdy_q && !rd_dat) |=> oe_q);

  // R9: error flags persist across cycles with no control write
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((pe_q || oe_q || fe_q) && !wr_ctl) |=> (pe_q || oe_q || fe_q));

endmodule

// File: rtl/async_rx_port.sv
module async_rx_port
  import rxp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FAC_MAX     = 64,
  parameter int MAX_BITS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxc,
  input  logic       rxd,
  output logic       rx_ready,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       err_frame
);

  logic                tick, rxd_s, done, perr, ferr, run;
  logic [MAX_BITS-1:0] char_w;
  mode_t               mode;

  rxp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rxc_i(rxc), .rxd_i(rxd),
    .tick_o(tick), .rxd_o(rxd_s)
  );

  rxp_frame #(.MAX_BITS(MAX_BITS), .FAC_MAX(FAC_MAX)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .rxd(rxd_s),
    .mode(mode), .done_o(done), .char_o(char_w), .perr_o(perr), .ferr_o(ferr)
  );

  rxp_host #(.MAX_BITS(MAX_BITS)) u_host (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done(done), .char_in(char_w),
    .perr_in(perr), .ferr_in(ferr), .mode(mode), .run(run),
    .rdy(rx_ready), .pe(err_parity), .oe(err_overrun), .fe(err_frame)
  );

  // R3 / R4: with reception off, the engine produces no character
  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done);

endmodule

// File: tb/async_rx_port_tb.sv
module async_rx_port_tb;

  logic       clk, rst_n, cs, rd, wr, addr, rxc, rxd;
  logic [7:0] wdata, rdata;
  logic       rx_ready, err_parity, err_overrun, err_frame;
  int         n_checks, n_fail;
  bit         finished;

  async_rx_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxc(rxc), .rxd(rxd),
    .rx_ready(rx_ready), .err_parity(err_parity),
    .err_overrun(err_overrun), .err_frame(err_frame)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mode_word(input int fac, input int len, input bit pen, input bit even);
    logic [1:0] fc;
    fc = (fac == 64) ? 2'b11 : (fac == 16) ? 2'b10 : 2'b01;
    return {2'b00, even, pen, 2'(len - 5), fc};
  endfunction

  function automatic logic [7:0] status_exp(input bit r, input bit p, input bit o, input bit f);
    return {2'b00, f, o, p, 1'b0, r, 1'b0};
  endfunction

  function automatic logic [7:0] len_mask(input int len);
    return 8'((9'd1 << len) - 9'd1);
  endfunction

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] q);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 q = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  // one receive-clock period of 8 system clocks, line changes while rxc is low
  task automatic line_period(input logic b);
    @(negedge clk);
    rxc = 1'b0; rxd = b;
    repeat (3) @(negedge clk);
    rxc = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic line_bit(input logic b, input int fac);
    for (int i = 0; i < fac; i++) line_period(b);
  endtask

  task automatic send_char(input logic [7:0] c, input int len, input bit pen, input bit even,
                           input bit bad_par, input bit stop_ok, input int fac);
    logic p;
    p = ^(c & len_mask(len));
    if (!even) p = ~p;
    if (bad_par) p = ~p;
    line_bit(1'b0, fac);
    for (int i = 0; i < len; i++) line_bit(c[i], fac);
    if (pen) line_bit(p, fac);
    line_bit(stop_ok, fac);
    line_period(1'b1);
    line_period(1'b1);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    finished = 1'b0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] q, c;
    int fac, len, sel;
    bit pen, even;
    n_checks = 0; n_fail = 0;
    cs = 0; rd = 0; wr = 0; addr = 0; wdata = 0; rxc = 0; rxd = 1;
    rst_n = 1'b0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset state
    check("R8 reset ready", {7'b0, rx_ready}, 8'h00);
    bus_read(1'b1, q);
    check("R12 reset status", q, 8'h00);

    // R3 nothing received before any programming
    send_char(8'h5A, 8, 0, 0, 0, 1, 1);
    check("R3 no rx before mode", {7'b0, rx_ready}, 8'h00);
    bus_write(1'b1, mode_word(1, 8, 0, 0));
    send_char(8'h5A, 8, 0, 0, 0, 1, 1);
    check("R3 no rx before command", {7'b0, rx_ready}, 8'h00);
    bus_write(1'b1, 8'h04);
    send_char(8'hA6, 8, 0, 0, 0, 1, 1);
    check("R8 ready after char", {7'b0, rx_ready}, 8'h01);
    bus_read(1'b0, q);
    check("R1 data 8-bit 1x", q, 8'hA6);
    check("R8 ready cleared by read", {7'b0, rx_ready}, 8'h00);

    // R4 disable gate
    bus_write(1'b1, 8'h00);
    send_char(8'h33, 8, 0, 0, 0, 1, 1);
    check("R4 disabled ignores line", {7'b0, rx_ready}, 8'h00);

    // random mode words and characters
    for (int k = 0; k < 24; k++) begin
      sel  = $urandom % 4;
      fac  = (sel == 0) ? 1 : (sel == 3) ? 64 : 16;
      len  = 5 + ($urandom % 4);
      pen  = $urandom % 2;
      even = $urandom % 2;
      c    = 8'($urandom);
      bus_write(1'b1, 8'h40);
      bus_write(1'b1, mode_word(fac, len, pen, even));
      bus_write(1'b1, 8'h14);
      send_char(c, len, pen, even, 0, 1, fac);
      bus_read(1'b1, q);
      check("R2 R5 R12 random status", q, status_exp(1, 0, 0, 0));
      bus_read(1'b0, q);
      check("R1 R2 random data", q, c & len_mask(len));
      check("R8 random ready clear", {7'b0, rx_ready}, 8'h00);
    end

    // R5 parity error, then R9 stickiness
    bus_write(1'b1, 8'h40);
    bus_write(1'b1, mode_word(16, 7, 1, 1));
    bus_write(1'b1, 8'h14);
    send_char(8'h4D, 7, 1, 1, 1, 1, 16);
    bus_read(1'b1, q);
    check("R5 parity error flagged", q, status_exp(1, 1, 0, 0));
    bus_read(1'b0, q);
    check("R5 data still delivered", q, 8'h4D);
    bus_write(1'b1, 8'h04);
    bus_read(1'b1, q);
    check("R9 flag kept without clear bit", q, status_exp(0, 1, 0, 0));
    bus_write(1'b1, 8'h14);
    bus_read(1'b1, q);
    check("R9 flag cleared by bit 4", q, status_exp(0, 0, 0, 0));

    // R6 framing error
    send_char(8'h15, 7, 1, 1, 0, 0, 16);
    repeat (200) @(negedge clk);
    bus_read(1'b1, q);
    check("R6 framing error flagged", q, status_exp(1, 0, 0, 1));
    bus_read(1'b0, q);
    check("R6 data delivered", q, 8'h15);
    bus_write(1'b1, 8'h14);

    // R7 overrun replaces old character
    send_char(8'h11, 7, 1, 1, 0, 1, 16);
    send_char(8'h6E, 7, 1, 1, 0, 1, 16);
    bus_read(1'b1, q);
    check("R7 overrun status", q, status_exp(1, 0, 1, 0));
    bus_read(1'b0, q);
    check("R7 newest kept", q, 8'h6E);
    bus_write(1'b1, 8'h14);

    // R10 start glitch rejected at 16x
    line_bit(1'b0, 3);
    line_bit(1'b1, 30);
    check("R10 glitch ignored", {7'b0, rx_ready}, 8'h00);
    bus_read(1'b1, q);
    check("R10 status after glitch", q, 8'h00);

    // R11 return to mode expectation
    bus_write(1'b1, 8'h40);
    send_char(8'h2B, 7, 1, 1, 0, 1, 16);
    check("R11 stopped after remode", {7'b0, rx_ready}, 8'h00);
    bus_write(1'b1, 8'h0E);
    send_char(8'hC3, 8, 0, 0, 0, 1, 16);
    check("R11 mode write not a command", {7'b0, rx_ready}, 8'h00);
    bus_write(1'b1, 8'h04);
    send_char(8'hC3, 8, 0, 0, 0, 1, 16);
    bus_read(1'b0, q);
    check("R11 new mode in force", q, 8'hC3);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule